// File: doc/BRIEF.md
# Descriptor-Driven Expansion Bus Transfer Engine

The engine takes a four-word request descriptor and carries out a run of single-word accesses on a 32-bit local expansion bus. Each run moves data between that bus and host shared memory. Dword 0 selects the direction, the completion interrupt, the address mode, the byte lanes and the access count. Dword 1 is the host buffer address. Dword 2 is the first local bus address. Dword 3 is reserved.

A write command fetches the host words into a 16-word internal buffer with one host read burst, then writes them out on the local bus. A read command collects every local bus read word in the same buffer. Only after the last local access does it send the whole buffer to host memory in one host write burst. A descriptor that breaks any rule is dropped without touching either bus, and a sticky error flag is raised.

Top module: `xbus_xfer_engine`

## Requirements
- R1: Opcode 6 (dword 0 bits 31:27) is a write. The engine issues one host read command (`hm_cmd_write`=0) at the dword 1 address with length N. It stores the N beats that arrive on `hm_rvalid`, then performs N local bus writes (`lb_we`=1) carrying those words in arrival order.
- R2: Opcode 7 is a read. The engine performs N local bus reads (`lb_we`=0). Once the last of them has completed, it issues one host write command (`hm_cmd_write`=1) at the dword 1 address with length N. The N write beats then carry the read words in access order.
- R3: With dword 0 bit 18 at 0, access i (counted from 0) uses local address dword2[30:0] + i, modulo 2^31.
- R4: With dword 0 bit 18 at 1, every access uses local address dword2[30:0].
- R5: On every local access `lb_be_n` equals the bitwise inverse of dword 0 bits 17:14. Bit 0 is the least significant byte lane.
- R6: With dword 0 bit 26 at 1, `irq` is high for exactly one cycle after the last local access or host beat of the command. With the bit at 0, `irq` stays low.
- R7: A descriptor is rejected when its opcode is not 6 or 7, when dword1[1:0] is nonzero, when dword2[31] is 0, when dword0[25:19] is nonzero, when dword 3 is nonzero, or when N exceeds 16. A rejected descriptor performs no local or host access and gives no interrupt. It sets `err_flag` in the cycle after acceptance. The next accepted valid descriptor clears `err_flag`.
- R8: N = 0 (dword 0 bits 13:0) completes with no local or host access, and `irq` still follows bit 26.
- R9: `lb_req` is held, with `lb_addr`, `lb_wdata` and `lb_be_n` stable, until a cycle where `lb_rdy` is high. Each such cycle completes exactly one access.
- R10: `desc_ready` is high only while the engine is idle. It falls in the cycle after a valid descriptor with N > 0 is accepted, and no local request or host command is active while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Engine idle, descriptor taken when valid |
| desc_word0 | input | 32 | Control word: opcode, interrupt enable, mode, byte enables, count |
| desc_word1 | input | 32 | Host buffer address |
| desc_word2 | input | 32 | First local address (bit 31 must be 1) |
| desc_word3 | input | 32 | Reserved, must be zero |
| hm_cmd_valid | output | 1 | Host burst command valid |
| hm_cmd_ready | input | 1 | Host burst command accepted |
| hm_cmd_write | output | 1 | 1 = write to host, 0 = read from host |
| hm_cmd_addr | output | 32 | Host burst start address |
| hm_cmd_len | output | CNTW | Burst length in words |
| hm_rvalid | input | 1 | Host read beat, one word per cycle, no back-pressure |
| hm_rdata | input | 32 | Host read data |
| hm_wvalid | output | 1 | Host write beat valid |
| hm_wready | input | 1 | Host write beat accepted |
| hm_wdata | output | 32 | Host write data |
| lb_req | output | 1 | Local bus access request |
| lb_rdy | input | 1 | Local bus access complete |
| lb_we | output | 1 | 1 = write, 0 = read |
| lb_addr | output | 31 | Local bus word address |
| lb_be_n | output | 4 | Active-low byte enables |
| lb_wdata | output | 32 | Local bus write data |
| lb_rdata | input | 32 | Local bus read data |
| irq | output | 1 | Completion pulse |
| err_flag | output | 1 | Last descriptor was rejected |

## Verification
The sweep runs both directions against every combination of the address mode and interrupt enable. It uses lengths 0, 1, 2, 5 and the full 16, with changing byte-lane patterns and local bus wait states of 0 to 2 cycles. The full-length runs start just below the top of the 31-bit address space, which separates wrapping increment from fixed addressing. Words returned by the local bus are unique per access, so any reordering or loss between the buffer and the host burst shows up. Each reject rule is tried alone, followed by a zero-length command that must clear the error flag.

// File: rtl/xbe_pkg.sv
package xbe_pkg;

  localparam logic [4:0] OPC_WRITE = 5'd6;
  localparam logic [4:0] OPC_READ  = 5'd7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HRD_CMD,
    ST_HRD_DATA,
    ST_LB_FETCH,
    ST_LB_ACC,
    ST_HWR_CMD,
    ST_HWR_FETCH,
    ST_HWR_BEAT,
    ST_DONE
  } xbe_state_t;

  typedef struct packed {
    logic        is_write;
    logic        irq_en;
    logic        fixed;
    logic [3:0]  lanes;
    logic [31:0] haddr;
    logic [30:0] lbase;
  } xbe_req_t;

endpackage

// File: rtl/xbe_desc_decode.sv
module xbe_desc_decode
  import xbe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic [31:0] w0,
  input  logic [31:0] w1,
  input  logic [31:0] w2,
  input  logic [31:0] w3,
  output xbe_req_t    req,
  output logic [CNTW-1:0] len,
  output logic        len_zero,
  output logic        ok
);

  logic [4:0]  opc;
  logic        opc_ok;
  logic        rsv_ok;
  logic        len_ok;

  assign opc      = w0[31:27];
  assign opc_ok   = (opc == OPC_WRITE) || (opc == OPC_READ);
  assign rsv_ok   = (w0[25:19] == 7'd0) && (w3 == 32'd0);
  assign len_ok   = (w0[13:0] <= 14'(DEPTH));
  assign len_zero = (w0[13:0] == 14'd0);
  assign len      = w0[CNTW-1:0];

  assign ok = opc_ok && rsv_ok && len_ok && (w1[1:0] == 2'b00) && w2[31];

  always_comb begin
    req.is_write = (opc == OPC_WRITE);
    req.irq_en   = w0[26];
    req.fixed    = w0[18];
    req.lanes    = w0[17:14];
    req.haddr    = w1;
    req.lbase    = w2[30:0];
  end

endmodule

// File: rtl/xbe_word_buf.sv
module xbe_word_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [IDXW-1:0] raddr,
  output logic [DW-1:0]   rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/xbe_addr_step.sv
module xbe_addr_step #(
  parameter int AW = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          fixed,
  input  logic          step,
  output logic [AW-1:0] addr
);

  logic fixed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      fixed_q <= 1'b0;
    end else if (load) begin
      addr    <= base;
      fixed_q <= fixed;
    end else if (step && !fixed_q) begin
      addr <= addr + AW'(1);
    end
  end

endmodule

// File: rtl/xbus_xfer_engine.sv
module xbus_xfer_engine
  import xbe_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int IDXW = $clog2(DEPTH),
  localparam int AW   = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            desc_valid,
  output logic            desc_ready,
  input  logic [31:0]     desc_word0,
  input  logic [31:0]     desc_word1,
  input  logic [31:0]     desc_word2,
  input  logic [31:0]     desc_word3,
  output logic            hm_cmd_valid,
  input  logic            hm_cmd_ready,
  output logic            hm_cmd_write,
  output logic [31:0]     hm_cmd_addr,
  output logic [CNTW-1:0] hm_cmd_len,
  input  logic            hm_rvalid,
  input  logic [DW-1:0]   hm_rdata,
  output logic            hm_wvalid,
  input  logic            hm_wready,
  output logic [DW-1:0]   hm_wdata,
  output logic            lb_req,
  input  logic            lb_rdy,
  output logic            lb_we,
  output logic [AW-1:0]   lb_addr,
  output logic [3:0]      lb_be_n,
  output logic [DW-1:0]   lb_wdata,
  input  logic [DW-1:0]   lb_rdata,
  output logic            irq,
  output logic            err_flag
);

  xbe_state_t      state;
  xbe_req_t        dec_req;
  xbe_req_t        req_q;
  logic [CNTW-1:0] dec_len;
  logic            dec_zero;
  logic            dec_ok;
  logic [CNTW-1:0] len_q;
  logic [CNTW-1:0] cnt;
  logic            last;
  logic            accept;
  logic            lb_done;
  logic            buf_we;
  logic [DW-1:0]   buf_wdata;
  logic [DW-1:0]   buf_rdata;

  xbe_desc_decode #(.DEPTH(DEPTH)) u_dec (
    .w0       (desc_word0),
    .w1       (desc_word1),
    .w2       (desc_word2),
    .w3       (desc_word3),
    .req      (dec_req),
    .len      (dec_len),
    .len_zero (dec_zero),
    .ok       (dec_ok)
  );

  assign desc_ready = (state == ST_IDLE);
  assign accept     = desc_valid && desc_ready;
  assign last       = (cnt == len_q - CNTW'(1));
  assign lb_done    = (state == ST_LB_ACC) && lb_req && lb_rdy;

  // Buffer is filled from the host on a write command, from the local bus on a read.
  assign buf_we    = ((state == ST_HRD_DATA) && hm_rvalid) ||
                     (lb_done && !req_q.is_write);
  assign buf_wdata = (state == ST_HRD_DATA) ? hm_rdata : lb_rdata;

  xbe_word_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (cnt[IDXW-1:0]),
    .wdata (buf_wdata),
    .raddr (cnt[IDXW-1:0]),
    .rdata (buf_rdata)
  );

  xbe_addr_step #(.AW(AW)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .load  (accept && dec_ok),
    .base  (dec_req.lbase),
    .fixed (dec_req.fixed),
    .step  (lb_done),
    .addr  (lb_addr)
  );

  // Buffer output register feeds both data outputs; its address is held while a beat waits.
  assign lb_wdata = req_q.is_write ? buf_rdata : '0;
  assign hm_wdata = buf_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      req_q        <= '0;
      len_q        <= '0;
      cnt          <= '0;
      hm_cmd_valid <= 1'b0;
      hm_cmd_write <= 1'b0;
      hm_cmd_addr  <= '0;
      hm_cmd_len   <= '0;
      hm_wvalid    <= 1'b0;
      lb_req       <= 1'b0;
      lb_we        <= 1'b0;
      lb_be_n      <= 4'hF;
      irq          <= 1'b0;
      err_flag     <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (dec_ok) begin
              req_q    <= dec_req;
              len_q    <= dec_len;
              cnt      <= '0;
              err_flag <= 1'b0;
              if (dec_zero) begin
                state <= ST_DONE;
              end else if (dec_req.is_write) begin
                hm_cmd_valid <= 1'b1;
                hm_cmd_write <= 1'b0;
                hm_cmd_addr  <= dec_req.haddr;
                hm_cmd_len   <= dec_len;
                state        <= ST_HRD_CMD;
              end else begin
                state <= ST_LB_FETCH;
              end
            end else begin
              err_flag <= 1'b1;
            end
          end
        end
        ST_HRD_CMD: begin
          if (hm_cmd_ready) begin
            hm_cmd_valid <= 1'b0;
            state        <= ST_HRD_DATA;
          end
        end
        ST_HRD_DATA: begin
          if (hm_rvalid) begin
            if (last) begin
              cnt   <= '0;
              state <= ST_LB_FETCH;
            end else begin
              cnt <= cnt + CNTW'(1);
            end
          end
        end
        ST_LB_FETCH: begin
          lb_req  <= 1'b1;
          lb_we   <= req_q.is_write;
          lb_be_n <= ~req_q.lanes;
          state   <= ST_LB_ACC;
        end
        ST_LB_ACC: begin
          if (lb_rdy) begin
            lb_req <= 1'b0;
            if (last) begin
              cnt <= '0;
              if (req_q.is_write) begin
                state <= ST_DONE;
              end else begin
                hm_cmd_valid <= 1'b1;
                hm_cmd_write <= 1'b1;
                hm_cmd_addr  <= req_q.haddr;
                hm_cmd_len   <= len_q;
                state        <= ST_HWR_CMD;
              end
            end else begin
              cnt   <= cnt + CNTW'(1);
              state <= ST_LB_FETCH;
            end
          end
        end
        ST_HWR_CMD: begin
          if (hm_cmd_ready) begin
            hm_cmd_valid <= 1'b0;
            state        <= ST_HWR_FETCH;
          end
        end
        ST_HWR_FETCH: begin
          hm_wvalid <= 1'b1;
          state     <= ST_HWR_BEAT;
        end
        ST_HWR_BEAT: begin
          if (hm_wready) begin
            hm_wvalid <= 1'b0;
            if (last) begin
              cnt   <= '0;
              state <= ST_DONE;
            end else begin
              cnt   <= cnt + CNTW'(1);
              state <= ST_HWR_FETCH;
            end
          end
        end
        ST_DONE: begin
          irq   <= req_q.irq_en;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xbe_checker.sv
module xbe_checker #(
  parameter int DEPTH = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            desc_valid,
  input logic            desc_ready,
  input logic [31:0]     desc_word0,
  input logic [31:0]     desc_word1,
  input logic [31:0]     desc_word2,
  input logic [31:0]     desc_word3,
  input logic            hm_cmd_valid,
  input logic            hm_cmd_write,
  input logic            hm_wvalid,
  input logic            lb_req,
  input logic            lb_rdy,
  input logic [30:0]     lb_addr,
  input logic [3:0]      lb_be_n,
  input logic [31:0]     lb_wdata,
  input logic            irq,
  input logic            err_flag
);

  logic [3:0]  cap_lanes;
  logic        cap_fixed;
  logic [30:0] cap_base;
  logic        bad_desc;

  assign bad_desc = !((desc_word0[31:27] == 5'd6) || (desc_word0[31:27] == 5'd7)) ||
                    (desc_word0[25:19] != 7'd0) || (desc_word3 != 32'd0) ||
                    (desc_word1[1:0] != 2'b00) || !desc_word2[31] ||
                    (desc_word0[13:0] > 14'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lanes <= '0;
      cap_fixed <= 1'b0;
      cap_base  <= '0;
    end else if (desc_valid && desc_ready && !bad_desc) begin
      cap_lanes <= desc_word0[17:14];
      cap_fixed <= desc_word0[18];
      cap_base  <= desc_word2[30:0];
    end
  end

  AST_LB_HOLD: assert property (@(posedge clk) disable iff (rst)
    lb_req && !lb_rdy |=> lb_req && $stable(lb_addr) && $stable(lb_wdata) && $stable(lb_be_n)); // R9

  AST_LANES_EVERY_ACCESS: assert property (@(posedge clk) disable iff (rst)
    lb_req |-> lb_be_n == ~cap_lanes); // R5

  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (rst)
    lb_req && cap_fixed |-> lb_addr == cap_base); // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    desc_ready |-> !lb_req && !hm_cmd_valid && !hm_wvalid); // R10

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    desc_valid && desc_ready && bad_desc |=> desc_ready && err_flag && !lb_req && !irq); // R7

  AST_HOST_WRITE_AFTER_LB: assert property (@(posedge clk) disable iff (rst)
    (hm_cmd_valid && hm_cmd_write) || hm_wvalid |-> !lb_req); // R2

endmodule

bind xbus_xfer_engine xbe_checker #(.DEPTH(DEPTH)) u_xbe_chk (
  .clk          (clk),
  .rst          (rst),
  .desc_valid   (desc_valid),
  .desc_ready   (desc_ready),
  .desc_word0   (desc_word0),
  .desc_word1   (desc_word1),
  .desc_word2   (desc_word2),
  .desc_word3   (desc_word3),
  .hm_cmd_valid (hm_cmd_valid),
  .hm_cmd_write (hm_cmd_write),
  .hm_wvalid    (hm_wvalid),
  .lb_req       (lb_req),
  .lb_rdy       (lb_rdy),
  .lb_addr      (lb_addr),
  .lb_be_n      (lb_be_n),
  .lb_wdata     (lb_wdata),
  .irq          (irq),
  .err_flag     (err_flag)
);

// File: tb/tb_xbus_xfer_engine.sv
module tb_xbus_xfer_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic desc_valid = 1'b0;
  logic desc_ready;
  logic [31:0] desc_word0 = '0, desc_word1 = '0, desc_word2 = '0, desc_word3 = '0;
  logic hm_cmd_valid, hm_cmd_write;
  logic hm_cmd_ready = 1'b1;
  logic [31:0] hm_cmd_addr;
  logic [CNTW-1:0] hm_cmd_len;
  logic hm_rvalid = 1'b0;
  logic [31:0] hm_rdata = '0;
  logic hm_wvalid;
  logic hm_wready = 1'b1;
  logic [31:0] hm_wdata;
  logic lb_req, lb_we;
  logic lb_rdy = 1'b0;
  logic [30:0] lb_addr;
  logic [3:0] lb_be_n;
  logic [31:0] lb_wdata;
  logic [31:0] lb_rdata = '0;
  logic irq, err_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_xfer_engine #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_word0(desc_word0), .desc_word1(desc_word1), .desc_word2(desc_word2),
    .desc_word3(desc_word3), .hm_cmd_valid(hm_cmd_valid), .hm_cmd_ready(hm_cmd_ready),
    .hm_cmd_write(hm_cmd_write), .hm_cmd_addr(hm_cmd_addr), .hm_cmd_len(hm_cmd_len),
    .hm_rvalid(hm_rvalid), .hm_rdata(hm_rdata), .hm_wvalid(hm_wvalid),
    .hm_wready(hm_wready), .hm_wdata(hm_wdata), .lb_req(lb_req), .lb_rdy(lb_rdy),
    .lb_we(lb_we), .lb_addr(lb_addr), .lb_be_n(lb_be_n), .lb_wdata(lb_wdata),
    .lb_rdata(lb_rdata), .irq(irq), .err_flag(err_flag)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int lb_lat = 0;

  // Local bus slave record
  int lb_n = 0;
  int wcnt = 0;
  logic [15:0] rd_seq = 16'h0100;
  logic [30:0] rec_a [256];
  logic        rec_w [256];
  logic [31:0] rec_d [256];
  logic [3:0]  rec_b [256];
  int          rec_t [256];

  // Host model record
  logic [31:0] hmem [64];
  int hw_n = 0, hc_n = 0, irq_n = 0, rleft = 0;
  logic [5:0] rptr = '0, wptr = '0;
  logic [31:0] hw_d [256];
  logic [31:0] hc_a;
  logic [CNTW-1:0] hc_l;
  logic hc_w;
  int hc_t;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    lb_rdy <= 1'b0;
    if (rst) begin
      wcnt <= 0;
    end else if (lb_req && !lb_rdy) begin
      if (wcnt >= lb_lat) begin
        lb_rdy   <= 1'b1;
        wcnt     <= 0;
        lb_rdata <= {lb_addr[15:0], rd_seq};
        rec_a[lb_n & 255] <= lb_addr;
        rec_w[lb_n & 255] <= lb_we;
        rec_d[lb_n & 255] <= lb_we ? lb_wdata : {lb_addr[15:0], rd_seq};
        rec_b[lb_n & 255] <= lb_be_n;
        rec_t[lb_n & 255] <= cyc;
        rd_seq <= rd_seq + 16'd1;
        lb_n   <= lb_n + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    hm_rvalid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 64; i++) hmem[i] <= 32'hC0DE_0000 + 32'(i * 17);
      rleft <= 0;
    end else begin
      if (hm_cmd_valid && hm_cmd_ready) begin
        hc_a <= hm_cmd_addr; hc_l <= hm_cmd_len; hc_w <= hm_cmd_write; hc_t <= cyc;
        hc_n <= hc_n + 1;
        if (!hm_cmd_write) begin
          rleft <= int'(hm_cmd_len);
          rptr  <= hm_cmd_addr[7:2];
        end else begin
          wptr <= hm_cmd_addr[7:2];
        end
      end else if (rleft > 0) begin
        hm_rvalid <= 1'b1;
        hm_rdata  <= hmem[rptr];
        rptr  <= rptr + 6'd1;
        rleft <= rleft - 1;
      end
      if (hm_wvalid && hm_wready) begin
        hmem[wptr] <= hm_wdata;
        hw_d[hw_n & 255] <= hm_wdata;
        hw_n <= hw_n + 1;
        wptr <= wptr + 6'd1;
      end
      if (irq) irq_n <= irq_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    summary();
  end

  task automatic run_cmd(input logic [4:0] op, input bit ien, input bit fixed,
                         input logic [3:0] lanes, input int len, input int widx,
                         input logic [30:0] base);
    int lb0, hw0, hc0, ir0, guard;
    logic [31:0] snap [16];
    string rq;
    lb0 = lb_n; hw0 = hw_n; hc0 = hc_n; ir0 = irq_n;
    for (int i = 0; i < 16; i++) snap[i] = hmem[(widx + i) & 63];
    @(negedge clk);
    chk(desc_ready == 1'b1, "R10", "ready before command", desc_ready, 1);
    desc_word0 = {op, ien, 7'd0, fixed, lanes, 14'(len)};
    desc_word1 = 32'(widx * 4);
    desc_word2 = {1'b1, base};
    desc_word3 = 32'd0;
    desc_valid = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0;
    if (len > 0) chk(desc_ready == 1'b0, "R10", "busy after accept", desc_ready, 0);
    guard = 0;
    while (!desc_ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    rq = (len == 0) ? "R8" : "R6";
    chk(irq_n - ir0 == (ien ? 1 : 0), rq, "interrupt pulse count", irq_n - ir0, ien ? 1 : 0);
    chk(err_flag == 1'b0, "R7", "error flag after valid command", err_flag, 0);
    rq = (op == 5'd6) ? "R1" : "R2";
    if (len == 0) rq = "R8";
    chk(lb_n - lb0 == len, rq, "local access count", lb_n - lb0, len);
    for (int i = 0; i < len; i++) begin
      logic [30:0] ea;
      int k;
      k = (lb0 + i) & 255;
      ea = fixed ? base : 31'(base + 31'(i));
      if (fixed) chk(rec_a[k] == ea, "R4", "fixed address", rec_a[k], ea);
      else       chk(rec_a[k] == ea, "R3", "incrementing address", rec_a[k], ea);
      chk(rec_b[k] == ~lanes, "R5", "byte enables", rec_b[k], ~lanes);
      chk(rec_w[k] == (op == 5'd6), rq, "access direction", rec_w[k], op == 5'd6);
      if (op == 5'd6) chk(rec_d[k] == snap[i], "R1", "local write data", rec_d[k], snap[i]);
    end
    if (len == 0) begin
      chk(hc_n == hc0, "R8", "no host command", hc_n - hc0, 0);
    end else begin
      chk(hc_n - hc0 == 1, rq, "host command count", hc_n - hc0, 1);
      chk(hc_a == 32'(widx * 4), rq, "host address", hc_a, widx * 4);
      chk(int'(hc_l) == len, rq, "host length", hc_l, len);
      chk(hc_w == (op == 5'd7), rq, "host direction", hc_w, op == 5'd7);
      if (op == 5'd7) begin
        chk(hc_t > rec_t[(lb0 + len - 1) & 255], "R2", "host burst after last read",
            hc_t, rec_t[(lb0 + len - 1) & 255] + 1);
        chk(hw_n - hw0 == len, "R2", "host beat count", hw_n - hw0, len);
        for (int i = 0; i < len; i++) begin
          chk(hw_d[(hw0 + i) & 255] == rec_d[(lb0 + i) & 255], "R2", "host beat data",
              hw_d[(hw0 + i) & 255], rec_d[(lb0 + i) & 255]);
          chk(hmem[(widx + i) & 63] == rec_d[(lb0 + i) & 255], "R2", "host memory word",
              hmem[(widx + i) & 63], rec_d[(lb0 + i) & 255]);
        end
      end
    end
  endtask

  task automatic run_reject(input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3, input string what);
    int lb0, hc0, ir0;
    lb0 = lb_n; hc0 = hc_n; ir0 = irq_n;
    @(negedge clk);
    desc_word0 = w0; desc_word1 = w1; desc_word2 = w2; desc_word3 = w3;
    desc_valid = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0;
    chk(err_flag == 1'b1, "R7", what, err_flag, 1);
    repeat (12) @(negedge clk);
    chk(desc_ready == 1'b1 && lb_n == lb0 && hc_n == hc0 && irq_n == ir0, "R7",
        {what, " no activity"}, (lb_n - lb0) + (hc_n - hc0) + (irq_n - ir0), 0);
    chk(err_flag == 1'b1, "R7", {what, " flag held"}, err_flag, 1);
    run_cmd(5'd6, 1'b0, 1'b0, 4'h3, 0, 0, 31'h10);
  endtask

  initial begin
    int k;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(desc_ready == 1'b1, "R10", "reset ready", desc_ready, 1);
    chk(lb_req == 1'b0 && hm_cmd_valid == 1'b0 && hm_wvalid == 1'b0, "R9", "reset quiet",
        {lb_req, hm_cmd_valid, hm_wvalid}, 0);
    chk(irq == 1'b0 && err_flag == 1'b0, "R6", "reset irq and error", {irq, err_flag}, 0);

    k = 0;
    for (int op = 6; op <= 7; op++) begin
      for (int li = 0; li < 5; li++) begin
        for (int fx = 0; fx < 2; fx++) begin
          for (int ie = 0; ie < 2; ie++) begin
            int len;
            logic [30:0] base;
            len = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 2 : (li == 3) ? 5 : 16;
            base = (len == 16) ? 31'h7FFF_FFF8 : 31'(32'h0000_4000 + 32'(k * 37));
            lb_lat = k % 3;
            run_cmd(5'(op), ie[0], fx[0], 4'(k * 3 + 1), len, (k * 7) % 48, base);
            k++;
          end
        end
      end
    end

    run_reject({5'd5, 1'b1, 7'd0, 1'b0, 4'hF, 14'd2}, 32'h40, 32'h8000_0010, 32'd0, "undefined opcode");
    run_reject({5'd0, 1'b1, 7'd0, 1'b0, 4'hF, 14'd2}, 32'h40, 32'h8000_0010, 32'd0, "zero opcode");
    run_reject({5'd7, 1'b1, 7'd0, 1'b0, 4'hF, 14'd2}, 32'h42, 32'h8000_0010, 32'd0, "misaligned buffer");
    run_reject({5'd6, 1'b1, 7'd0, 1'b0, 4'hF, 14'd2}, 32'h40, 32'h0000_0010, 32'd0, "address bit 31 clear");
    run_reject({5'd7, 1'b1, 7'h04, 1'b0, 4'hF, 14'd2}, 32'h40, 32'h8000_0010, 32'd0, "reserved bits set");
    run_reject({5'd6, 1'b1, 7'd0, 1'b0, 4'hF, 14'd2}, 32'h40, 32'h8000_0010, 32'h1, "dword 3 nonzero");
    run_reject({5'd7, 1'b1, 7'd0, 1'b0, 4'hF, 14'd17}, 32'h40, 32'h8000_0010, 32'd0, "length 17");

    lb_lat = 2;
    run_cmd(5'd6, 1'b1, 1'b0, 4'h1, 16, 47, 31'h0000_0100);
    run_cmd(5'd7, 1'b1, 1'b1, 4'h8, 16, 0, 31'h7FFF_FFFF);

    summary();
  end

endmodule